// File: doc/BRIEF.md
# Extended-Precision Compare Condition Unit

This unit compares the value at the top of a floating-point register stack with a double-precision memory operand. The register value is an 80-bit extended-precision word: sign in bit 79, a 15-bit exponent in bits 78:64, and a 64-bit significand with an explicit integer bit in bit 63. The memory operand is a 64-bit double. Inside the unit the double is widened to the extended format, so both operands are ordered on the same scale and the comparison loses no precision.

A single-cycle `start_i` pulse samples all inputs. One cycle later `done_o` pulses, and the results are valid on the outputs:

- the four condition-code bits;
- three exception flags (invalid operation, denormal operand, stack fault);
- a pop request for the register-stack controller.

These outputs hold their values until the next start. The unit checks three things before it compares. It handles an empty top register first. It then detects NaN and unsupported encodings, which give an unordered result. Last, it decides whether the stack may be popped, using the invalid-operation mask and an instruction-supplied pop enable.

Top module: `xcmp_cc_unit`

## Requirements
- R1: After reset, `done_o`, `pop_o`, every exception flag and all four bits of `cc_o` are 0.
- R2: A `start_i` sampled high at a clock edge makes `done_o` high for exactly the following cycle, with the results valid on the outputs. The results then hold unchanged, whatever the inputs do, until the next sampled start.
- R3: `cc_o` is {C3, C2, C1, C0}. The codes are: greater 4'b0000, less 4'b0001, equal 4'b1000, unordered 4'b1101. C1 is always 0 after a comparison.
- R4: For ordered operands the result is the numeric relation of the top value to the double. The double is widened exactly, so an extended value that differs from it by one unit in the last place is unequal. Signs are respected, infinities are ordered at the extremes, and +0 equals -0.
- R5: If `top_empty_i` is set, the unit reports the following, whatever the operand values are:
  - `exc_stack_o` = 1 and `exc_invalid_o` = 1;
  - `exc_denorm_o` = 0;
  - `cc_o` = 4'b1101;
  - `pop_o` = `pop_en_i` AND `inv_mask_i`.
- R6: A NaN or unsupported top value, or a NaN double, gives `cc_o` = 4'b1101 and `exc_invalid_o` = 1, with `exc_stack_o` = 0.
- R7: A top value is unsupported when its integer bit (bit 63) is 0 and its exponent is nonzero. This includes the all-ones exponent.
- R8: On the ordered path, a denormal operand sets `exc_denorm_o` and is still compared by value. A denormal operand is either an extended value with exponent 0 and a nonzero significand, or a double with exponent 0 and a nonzero fraction. The flag is not set on the empty or unordered paths.
- R9: When the top register is not empty, `pop_o` = `pop_en_i` AND NOT (`exc_invalid_o` AND NOT `inv_mask_i`). A denormal flag never withholds the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins one comparison; all operands sampled with it |
| top_val_i | input | 80 | Top-of-stack extended value {sign, exponent, significand} |
| top_empty_i | input | 1 | Top register is tagged empty |
| mem_dbl_i | input | 64 | Double-precision memory operand |
| inv_mask_i | input | 1 | Invalid-operation exception is masked |
| pop_en_i | input | 1 | Instruction asks for a pop after the compare |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 4 | Condition codes {C3, C2, C1, C0} |
| exc_invalid_o | output | 1 | Invalid-operation flag |
| exc_denorm_o | output | 1 | Denormal-operand flag |
| exc_stack_o | output | 1 | Stack-fault (underflow) flag |
| pop_o | output | 1 | Pop request to the stack controller |

## Verification
The bench targets the following corner cases:

- **Widening.** A double denormal must land on exactly the extended exponent that the bench computes. A widening that ignores the leading-zero count reports less or greater instead of equal. An extended value one unit above 1.0 must compare greater. A design that truncates the extended significand calls it equal.
- **Signed zero and negative operands.** A design that compares raw bit patterns gets these wrong: it calls +0 and -0 unequal and reverses the order of negative values.
- **Special encodings.** The bench drives an integer-bit-clear normal value and a pseudo-NaN (all-ones exponent, integer bit clear). A classifier that misses them returns an ordered code with no invalid flag.
- **Empty register and pop gating.** The empty case is run with a NaN payload, and the pop is driven under both mask settings. A design that tests NaN before emptiness, or that pops after an unmasked invalid, shows up in the flags and the pop output.

// File: rtl/xcmp_pkg.sv
package xcmp_pkg;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } xcmp_rel_e;

  typedef struct packed {
    logic is_zero;
    logic is_denorm;
    logic is_inf;
    logic is_nan;
    logic is_unsup;
  } xcmp_class_t;

  // {C3, C2, C1, C0}; C1 is cleared for every comparison
  function automatic logic [3:0] rel_to_cc(input xcmp_rel_e rel);
    logic [3:0] cc;
    case (rel)
      REL_GT:  cc = 4'b0000;
      REL_LT:  cc = 4'b0001;
      REL_EQ:  cc = 4'b1000;
      default: cc = 4'b1101;
    endcase
    return cc;
  endfunction

endpackage

// File: rtl/xcmp_classify.sv
module xcmp_classify
  import xcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [MAN_W-1:0]       man_i,
  output xcmp_class_t            cls_o,
  output logic [EXP_W+MAN_W-1:0] key_o
);
  localparam int KEY_W = EXP_W + MAN_W;

  logic exp_ones, exp_zero, int_bit, frac_nz, man_nz;

  always_comb begin
    exp_ones = &exp_i;
    exp_zero = (exp_i == '0);
    int_bit  = man_i[MAN_W-1];
    frac_nz  = |man_i[MAN_W-2:0];
    man_nz   = int_bit | frac_nz;

    cls_o.is_unsup  = !exp_zero && !int_bit;
    cls_o.is_nan    = exp_ones && int_bit && frac_nz;
    cls_o.is_inf    = exp_ones && int_bit && !frac_nz;
    cls_o.is_zero   = exp_zero && !man_nz;
    cls_o.is_denorm = exp_zero && man_nz;
  end

  // exponent 0 scales like exponent 1, so a single key orders all magnitudes
  logic [EXP_W-1:0] eff_exp;
  assign eff_exp = exp_zero ? EXP_W'(1) : exp_i;
  assign key_o   = KEY_W'({eff_exp, man_i});

endmodule

// File: rtl/xcmp_widen.sv
module xcmp_widen #(
  parameter int DEXP_W  = 11,
  parameter int DFRAC_W = 52,
  parameter int XEXP_W  = 15,
  parameter int XMAN_W  = 64
) (
  input  logic [DEXP_W+DFRAC_W:0] dbl_i,
  output logic                    sign_o,
  output logic [XEXP_W-1:0]       exp_o,
  output logic [XMAN_W-1:0]       man_o,
  output logic                    nan_o,
  output logic                    denorm_o
);
  localparam int DBIAS = (1 << (DEXP_W - 1)) - 1;
  localparam int XBIAS = (1 << (XEXP_W - 1)) - 1;
  localparam int OFFS  = XBIAS - DBIAS;
  localparam int PAD   = XMAN_W - DFRAC_W;
  localparam int LZ_W  = $clog2(DFRAC_W + 1);

  logic [DEXP_W-1:0]  d_exp;
  logic [DFRAC_W-1:0] d_frac;
  logic               e_zero, e_ones, f_nz;
  logic [LZ_W-1:0]    lz;

  assign sign_o = dbl_i[DEXP_W+DFRAC_W];
  assign d_exp  = dbl_i[DEXP_W+DFRAC_W-1:DFRAC_W];
  assign d_frac = dbl_i[DFRAC_W-1:0];
  assign e_zero = (d_exp == '0);
  assign e_ones = &d_exp;
  assign f_nz   = |d_frac;

  // leading-zero count of the fraction, used to normalise denormals
  always_comb begin
    lz = '0;
    for (int i = 0; i < DFRAC_W; i++) begin
      if (d_frac[i]) lz = LZ_W'(DFRAC_W - 1 - i);
    end
  end

  logic [XMAN_W-1:0] man_den;
  assign man_den = {d_frac, {PAD{1'b0}}} << lz;

  always_comb begin
    nan_o    = e_ones && f_nz;
    denorm_o = e_zero && f_nz;
    if (e_zero && !f_nz) begin
      exp_o = '0;
      man_o = '0;
    end else if (e_zero) begin
      exp_o = XEXP_W'(OFFS) - XEXP_W'(lz);
      man_o = man_den;
    end else if (e_ones) begin
      exp_o = '1;
      man_o = {1'b1, d_frac, {(PAD-1){1'b0}}};
    end else begin
      exp_o = XEXP_W'(d_exp) + XEXP_W'(OFFS);
      man_o = {1'b1, d_frac, {(PAD-1){1'b0}}};
    end
  end

endmodule

// File: rtl/xcmp_order.sv
module xcmp_order
  import xcmp_pkg::*;
#(
  parameter int KEY_W = 79
) (
  input  logic             sign_a_i,
  input  logic [KEY_W-1:0] key_a_i,
  input  logic             zero_a_i,
  input  logic             sign_b_i,
  input  logic [KEY_W-1:0] key_b_i,
  input  logic             zero_b_i,
  output xcmp_rel_e        rel_o
);
  logic mag_gt, mag_eq;

  assign mag_gt = key_a_i > key_b_i;
  assign mag_eq = key_a_i == key_b_i;

  always_comb begin
    if (zero_a_i && zero_b_i) begin
      rel_o = REL_EQ;
    end else if (sign_a_i != sign_b_i) begin
      rel_o = sign_a_i ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel_o = REL_EQ;
    end else if (mag_gt ^ sign_a_i) begin
      rel_o = REL_GT;
    end else begin
      rel_o = REL_LT;
    end
  end

endmodule

// File: rtl/xcmp_cc_unit.sv
module xcmp_cc_unit
  import xcmp_pkg::*;
#(
  parameter int XEXP_W  = 15,
  parameter int XMAN_W  = 64,
  parameter int DEXP_W  = 11,
  parameter int DFRAC_W = 52
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic [XEXP_W+XMAN_W:0]       top_val_i,
  input  logic                         top_empty_i,
  input  logic [DEXP_W+DFRAC_W:0]      mem_dbl_i,
  input  logic                         inv_mask_i,
  input  logic                         pop_en_i,
  output logic                         done_o,
  output logic [3:0]                   cc_o,
  output logic                         exc_invalid_o,
  output logic                         exc_denorm_o,
  output logic                         exc_stack_o,
  output logic                         pop_o
);
  localparam int XW    = 1 + XEXP_W + XMAN_W;
  localparam int KEY_W = XEXP_W + XMAN_W;

  // operand fields
  logic              a_sign;
  logic [XEXP_W-1:0] a_exp;
  logic [XMAN_W-1:0] a_man;
  assign a_sign = top_val_i[XW-1];
  assign a_exp  = top_val_i[XW-2:XMAN_W];
  assign a_man  = top_val_i[XMAN_W-1:0];

  logic              b_sign, b_nan, b_den;
  logic [XEXP_W-1:0] b_exp;
  logic [XMAN_W-1:0] b_man;

  xcmp_widen #(
    .DEXP_W(DEXP_W), .DFRAC_W(DFRAC_W), .XEXP_W(XEXP_W), .XMAN_W(XMAN_W)
  ) u_widen (
    .dbl_i(mem_dbl_i), .sign_o(b_sign), .exp_o(b_exp), .man_o(b_man),
    .nan_o(b_nan), .denorm_o(b_den)
  );

  xcmp_class_t      a_cls, b_cls;
  logic [KEY_W-1:0] a_key, b_key;

  xcmp_classify #(.EXP_W(XEXP_W), .MAN_W(XMAN_W)) u_cls_top (
    .exp_i(a_exp), .man_i(a_man), .cls_o(a_cls), .key_o(a_key)
  );

  xcmp_classify #(.EXP_W(XEXP_W), .MAN_W(XMAN_W)) u_cls_mem (
    .exp_i(b_exp), .man_i(b_man), .cls_o(b_cls), .key_o(b_key)
  );

  xcmp_rel_e ord_rel;

  xcmp_order #(.KEY_W(KEY_W)) u_order (
    .sign_a_i(a_sign), .key_a_i(a_key), .zero_a_i(a_cls.is_zero),
    .sign_b_i(b_sign), .key_b_i(b_key), .zero_b_i(b_cls.is_zero),
    .rel_o(ord_rel)
  );

  // outcome selection: empty, then unordered, then ordered
  xcmp_rel_e nx_rel;
  logic      nx_inv, nx_den, nx_stk, nx_pop;

  always_comb begin
    nx_rel = ord_rel;
    nx_inv = 1'b0;
    nx_den = 1'b0;
    nx_stk = 1'b0;
    nx_pop = pop_en_i;
    if (top_empty_i) begin
      nx_rel = REL_UN;
      nx_inv = 1'b1;
      nx_stk = 1'b1;
      nx_pop = pop_en_i && inv_mask_i;
    end else if (a_cls.is_nan || a_cls.is_unsup || b_nan) begin
      nx_rel = REL_UN;
      nx_inv = 1'b1;
      nx_pop = pop_en_i && inv_mask_i;
    end else begin
      nx_den = a_cls.is_denorm || b_den;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o        <= 1'b0;
      cc_o          <= '0;
      exc_invalid_o <= 1'b0;
      exc_denorm_o  <= 1'b0;
      exc_stack_o   <= 1'b0;
      pop_o         <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        cc_o          <= rel_to_cc(nx_rel);
        exc_invalid_o <= nx_inv;
        exc_denorm_o  <= nx_den;
        exc_stack_o   <= nx_stk;
        pop_o         <= nx_pop;
      end
    end
  end

endmodule

// File: rtl/xcmp_cc_chk.sv
module xcmp_cc_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       inv_mask_i,
  input logic       pop_en_i,
  input logic       done_o,
  input logic [3:0] cc_o,
  input logic       exc_invalid_o,
  input logic       exc_denorm_o,
  input logic       exc_stack_o,
  input logic       pop_o
);

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i));

  p_hold_results_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(start_i) |-> ($stable(cc_o) && $stable(pop_o) &&
                         $stable({exc_invalid_o, exc_denorm_o, exc_stack_o})));

  p_c1_clear_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !cc_o[1]);

  p_c2_only_unordered_r3: assert property (@(posedge clk) disable iff (rst)
    cc_o[2] |-> (cc_o[3] && cc_o[0]));

  p_stack_fault_r5: assert property (@(posedge clk) disable iff (rst)
    exc_stack_o |-> (cc_o == 4'b1101 && exc_invalid_o && !exc_denorm_o));

  p_invalid_unordered_r6: assert property (@(posedge clk) disable iff (rst)
    exc_invalid_o |-> (cc_o == 4'b1101));

  p_denorm_ordered_r8: assert property (@(posedge clk) disable iff (rst)
    exc_denorm_o |-> !exc_invalid_o);

  p_pop_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && pop_o) |-> ($past(pop_en_i) && (!exc_invalid_o || $past(inv_mask_i))));

endmodule

bind xcmp_cc_unit xcmp_cc_chk u_xcmp_cc_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .inv_mask_i(inv_mask_i),
  .pop_en_i(pop_en_i), .done_o(done_o), .cc_o(cc_o),
  .exc_invalid_o(exc_invalid_o), .exc_denorm_o(exc_denorm_o),
  .exc_stack_o(exc_stack_o), .pop_o(pop_o)
);

// File: tb/test_xcmp_cc_unit.sv
`timescale 1ns/1ps
module test_xcmp_cc_unit;

  localparam logic [3:0] CC_GT = 4'b0000;
  localparam logic [3:0] CC_LT = 4'b0001;
  localparam logic [3:0] CC_EQ = 4'b1000;
  localparam logic [3:0] CC_UN = 4'b1101;

  localparam logic [79:0] X_ONE   = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] X_TWO   = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] X_MONE  = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] X_MTWO  = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] X_PZERO = 80'h0;
  localparam logic [79:0] X_INF   = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] X_QNAN  = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};

  localparam logic [63:0] D_ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_MONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] D_MTWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] D_MZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_PZERO = 64'h0;
  localparam logic [63:0] D_MIN   = 64'h0000_0000_0000_0001;
  localparam logic [63:0] D_MAX   = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] D_INF   = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] D_NAN   = 64'h7FF8_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [79:0] top_val_i = '0;
  logic        top_empty_i = 1'b0;
  logic [63:0] mem_dbl_i = '0;
  logic        inv_mask_i = 1'b0;
  logic        pop_en_i = 1'b0;
  logic        done_o;
  logic [3:0]  cc_o;
  logic        exc_invalid_o, exc_denorm_o, exc_stack_o, pop_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xcmp_cc_unit i_xcmp_cc_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .top_val_i(top_val_i),
    .top_empty_i(top_empty_i), .mem_dbl_i(mem_dbl_i), .inv_mask_i(inv_mask_i),
    .pop_en_i(pop_en_i), .done_o(done_o), .cc_o(cc_o),
    .exc_invalid_o(exc_invalid_o), .exc_denorm_o(exc_denorm_o),
    .exc_stack_o(exc_stack_o), .pop_o(pop_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one comparison; results sampled in the done cycle and one cycle later
  task automatic run_cmp(input string req, input logic [79:0] xv, input logic empty,
                         input logic [63:0] dv, input logic mask, input logic popen,
                         input logic [3:0] e_cc, input logic e_inv, input logic e_den,
                         input logic e_stk, input logic e_pop);
    logic [7:0] got, want;
    @(negedge clk);
    start_i = 1'b1; top_val_i = xv; top_empty_i = empty; mem_dbl_i = dv;
    inv_mask_i = mask; pop_en_i = popen;
    @(negedge clk);
    start_i = 1'b0;
    top_val_i = ~xv; mem_dbl_i = ~dv; top_empty_i = ~empty;
    inv_mask_i = ~mask; pop_en_i = ~popen;
    got  = {done_o, exc_invalid_o, exc_denorm_o, exc_stack_o, pop_o, 3'b0};
    want = {1'b1, e_inv, e_den, e_stk, e_pop, 3'b0};
    check(cc_o == e_cc, req, "cc", {4'h0, cc_o}, {4'h0, e_cc});
    check(got == want, req, "done/inv/den/stk/pop", got, want);
    @(negedge clk);
    got  = {done_o, exc_invalid_o, exc_denorm_o, exc_stack_o, pop_o, 3'b0};
    want = {1'b0, e_inv, e_den, e_stk, e_pop, 3'b0};
    check(cc_o == e_cc && got == want, "R2", "hold after done",
          {cc_o, got[6:3]}, {e_cc, want[6:3]});
  endtask

  task automatic t_reset();
    check({done_o, cc_o, exc_invalid_o, exc_denorm_o, exc_stack_o, pop_o} == '0,
          "R1", "reset state",
          {done_o, cc_o, exc_invalid_o, exc_denorm_o, exc_stack_o},
          8'h00);
    check(pop_o == 1'b0, "R1", "reset pop", {7'h0, pop_o}, 8'h00);
  endtask

  task automatic t_ordered();
    run_cmp("R4", X_ONE,  0, D_ONE,  0, 0, CC_EQ, 0, 0, 0, 0);
    run_cmp("R4", X_TWO,  0, D_ONE,  0, 0, CC_GT, 0, 0, 0, 0);
    run_cmp("R4", X_ONE,  0, D_TWO,  0, 0, CC_LT, 0, 0, 0, 0);
    run_cmp("R4", X_MONE, 0, D_ONE,  0, 0, CC_LT, 0, 0, 0, 0);
    run_cmp("R4", X_MTWO, 0, D_MONE, 0, 0, CC_LT, 0, 0, 0, 0);
    run_cmp("R4", X_MONE, 0, D_MTWO, 0, 0, CC_GT, 0, 0, 0, 0);
    // one ulp above 1.0 in extended precision
    run_cmp("R4", {1'b0, 15'h3FFF, 64'h8000_0000_0000_0001}, 0, D_ONE, 0, 0,
            CC_GT, 0, 0, 0, 0);
  endtask

  task automatic t_zero_inf();
    run_cmp("R4", X_PZERO, 0, D_MZERO, 0, 0, CC_EQ, 0, 0, 0, 0);
    run_cmp("R4", {1'b1, 79'h0}, 0, D_PZERO, 0, 0, CC_EQ, 0, 0, 0, 0);
    run_cmp("R4", X_INF, 0, D_MAX, 0, 0, CC_GT, 0, 0, 0, 0);
    run_cmp("R4", X_INF, 0, D_INF, 0, 0, CC_EQ, 0, 0, 0, 0);
  endtask

  task automatic t_denorm();
    // 2^-1074 widened: exponent 16383-1074 = 0x3BCD, integer bit set
    run_cmp("R8", {1'b0, 15'h3BCD, 64'h8000_0000_0000_0000}, 0, D_MIN, 0, 0,
            CC_EQ, 0, 1, 0, 0);
    run_cmp("R8", X_PZERO, 0, D_MIN, 0, 0, CC_LT, 0, 1, 0, 0);
    run_cmp("R8", {1'b0, 15'h0, 64'h1}, 0, D_PZERO, 0, 1, CC_GT, 0, 1, 0, 1);
  endtask

  task automatic t_unordered();
    run_cmp("R6", X_QNAN, 0, D_ONE, 0, 1, CC_UN, 1, 0, 0, 0);
    run_cmp("R6", X_ONE,  0, D_NAN, 1, 1, CC_UN, 1, 0, 0, 1);
    run_cmp("R7", {1'b0, 15'h3FFF, 64'h0}, 0, D_ONE, 0, 0, CC_UN, 1, 0, 0, 0);
    run_cmp("R7", {1'b0, 15'h7FFF, 64'h4000_0000_0000_0000}, 0, D_ONE, 0, 0,
            CC_UN, 1, 0, 0, 0);
  endtask

  task automatic t_empty();
    run_cmp("R5", X_QNAN, 1, D_MIN, 0, 1, CC_UN, 1, 0, 1, 0);
    run_cmp("R5", X_ONE,  1, D_ONE, 1, 1, CC_UN, 1, 0, 1, 1);
    run_cmp("R5", X_ONE,  1, D_ONE, 1, 0, CC_UN, 1, 0, 1, 0);
  endtask

  task automatic t_pop();
    run_cmp("R9", X_TWO, 0, D_ONE, 0, 1, CC_GT, 0, 0, 0, 1);
    run_cmp("R9", X_TWO, 0, D_ONE, 1, 0, CC_GT, 0, 0, 0, 0);
    run_cmp("R9", X_QNAN, 0, D_ONE, 1, 1, CC_UN, 1, 0, 0, 1);
  endtask

  task automatic t_c1();
    // C1 clear after an empty register with sign set (R3)
    run_cmp("R3", {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000}, 1, D_MONE, 0, 0,
            CC_UN, 1, 0, 1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ordered();
    t_zero_inf();
    t_denorm();
    t_unordered();
    t_empty();
    t_pop();
    t_c1();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule